// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between clocked on-chip logic and an external asynchronous static RAM of 256K words by 4 bits. Client logic issues one access at a time over a valid/ready handshake: an 18-bit word address, a write flag and 4 bits of write data. The controller then plays out the strobe sequence on the memory pins and, for a read, returns the captured word with a one-cycle valid strobe.

All memory timing is expressed in nanoseconds and converted to clock counts at elaboration time. Each count is the ceiling of the nanosecond figure divided by the clock period parameter, with a floor of one cycle. A read asserts chip select and output enable together and holds them until both the address-access and output-enable delays have passed. A write pulls chip select and write enable low, keeps output enable high, and waits out the memory's output-off delay before driving data. It then drives data long enough to satisfy the data setup figure and releases the bus on the same edge that ends the write pulse.

Top module: `asram_ctl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, mem_cs_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, req_ready is 1 and rsp_valid is 0.
- R2: During a read access mem_cs_n=0, mem_oe_n=0, mem_we_n=1 and mem_dq_oe=0 on every cycle that output enable is low.
- R3: During a write access mem_cs_n=0, mem_we_n=0 and mem_oe_n=1 on every cycle that write enable is low.
- R4: A read keeps chip select and output enable low for at least max(ceil(70/CLK_NS), ceil(30/CLK_NS)) cycles, and the returned word is the bus value on the last clock edge before they rise.
- R5: The write-enable low pulse lasts at least 45 ns and at least 60 ns (whole cycles of CLK_NS), with chip select low and the address valid throughout it.
- R6: mem_dq_oe is 1 only while mem_we_n=0 and mem_oe_n=1; it rises no sooner than ceil(30/CLK_NS) cycles after write enable falls and after output enable last rose, stays high with stable data for at least ceil(30/CLK_NS) cycles, and is 0 on the cycle write enable rises.
- R7: Two successive falling edges of chip select are at least ceil(70/CLK_NS) cycles apart.
- R8: mem_addr equals the accepted request address and does not change while chip select stays low.
- R9: req_ready is 1 only when no access is in progress; a request is taken on a clock edge where req_valid and req_ready are both 1, and each read produces exactly one rsp_valid pulse of one cycle.
- R10: rsp_rdata on the rsp_valid cycle equals the last value written to that address through the controller, or the memory's prior content for an address never written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, period CLK_NS |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 18 | Word address |
| req_wdata | input | 4 | Write data |
| rsp_valid | output | 1 | One-cycle read data strobe |
| rsp_rdata | output | 4 | Read data |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_addr | output | 18 | Memory address bus |
| mem_dq_out | output | 4 | Data toward the memory pad |
| mem_dq_oe | output | 1 | Pad output enable for mem_dq_out |
| mem_dq_in | input | 4 | Data from the memory pad |

## Verification
The embedded properties assume the client keeps req_addr, req_write and req_wdata steady while req_valid waits for req_ready, and that mem_dq_in settles within one clock of a strobe change. The bench meets this by changing request fields only after a posedge and while no request is pending, and by letting its memory model return the stored word only once output enable has been low long enough. Before that point the model returns the inverted word, so a capture made too early shows up as a data mismatch.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

   typedef enum logic [2:0] {
      PH_IDLE,
      PH_READ,
      PH_WSETTLE,
      PH_WDRIVE,
      PH_WRECOVER
   } phase_e;

   function automatic int ns_to_cycles(input int ns, input int period_ns);
      int c;
      c = (ns + period_ns - 1) / period_ns;
      return (c < 1) ? 1 : c;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/asram_wait_timer.sv
`timescale 1ns/1ps
module asram_wait_timer #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             done
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_phase_fsm.sv
`timescale 1ns/1ps
module asram_phase_fsm
   import asram_pkg::*;
#(
   parameter int CNT_W = 5,
   parameter int RD_N  = 18,
   parameter int HZ_N  = 8,
   parameter int DRV_N = 8,
   parameter int REC_N = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic             tmr_done,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             accept,
   output logic             capture,
   output logic             idle,
   output logic             cs_n,
   output logic             oe_n,
   output logic             we_n,
   output logic             dq_oe
);

   phase_e ph_q, ph_d;

   always_comb begin
      ph_d     = ph_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      case (ph_q)
         PH_IDLE: if (req_valid) begin
            tmr_load = 1'b1;
            if (req_write) begin
               ph_d    = PH_WSETTLE;
               tmr_val = CNT_W'(HZ_N - 1);
            end else begin
               ph_d    = PH_READ;
               tmr_val = CNT_W'(RD_N - 1);
            end
         end
         PH_READ: if (tmr_done) ph_d = PH_IDLE;
         PH_WSETTLE: if (tmr_done) begin
            ph_d     = PH_WDRIVE;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(DRV_N - 1);
         end
         PH_WDRIVE: if (tmr_done) begin
            ph_d     = PH_WRECOVER;
            tmr_load = 1'b1;
            tmr_val  = CNT_W'(REC_N - 1);
         end
         PH_WRECOVER: if (tmr_done) ph_d = PH_IDLE;
         default: ph_d = PH_IDLE;
      endcase
   end

   assign idle    = (ph_q == PH_IDLE);
   assign accept  = idle && req_valid;
   assign capture = (ph_q == PH_READ) && tmr_done;

   // Strobes are registered from the next phase so the pins never glitch
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q  <= PH_IDLE;
         cs_n  <= 1'b1;
         oe_n  <= 1'b1;
         we_n  <= 1'b1;
         dq_oe <= 1'b0;
      end else begin
         ph_q  <= ph_d;
         cs_n  <= !(ph_d == PH_READ || ph_d == PH_WSETTLE || ph_d == PH_WDRIVE);
         oe_n  <= (ph_d != PH_READ);
         we_n  <= !(ph_d == PH_WSETTLE || ph_d == PH_WDRIVE);
         dq_oe <= (ph_d == PH_WDRIVE);
      end
   end

   // R6: the pad drives only inside a write pulse with output enable off
   p_drive_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> (!we_n && oe_n && !cs_n));

   // R3: write enable low implies a write encoding
   p_write_enc_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> (!cs_n && oe_n));

endmodule

// File: rtl/asram_data_path.sv
`timescale 1ns/1ps
module asram_data_path #(
   parameter int ADDR_W = 18,
   parameter int DATA_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   input  logic [DATA_W-1:0] mem_dq_in,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata
);

   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [DATA_W-1:0] rdata_q;
   logic              rvld_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         addr_q  <= '0;
         wdata_q <= '0;
      end else if (accept) begin
         addr_q  <= req_addr;
         wdata_q <= req_wdata;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rdata_q <= '0;
         rvld_q  <= 1'b0;
      end else begin
         rvld_q <= capture;
         if (capture) rdata_q <= mem_dq_in;
      end
   end

   assign mem_addr   = addr_q;
   assign mem_dq_out = wdata_q;
   assign rsp_valid  = rvld_q;
   assign rsp_rdata  = rdata_q;

endmodule

// File: rtl/asram_ctl.sv
`timescale 1ns/1ps
module asram_ctl
   import asram_pkg::*;
#(
   parameter int ADDR_W  = 18,
   parameter int DATA_W  = 4,
   parameter int CLK_NS  = 4,
   parameter int T_RC_NS = 70,
   parameter int T_OE_NS = 30,
   parameter int T_WP_NS = 45,
   parameter int T_AW_NS = 60,
   parameter int T_DW_NS = 30,
   parameter int T_WC_NS = 70,
   parameter int T_HZ_NS = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              mem_cs_n,
   output logic              mem_oe_n,
   output logic              mem_we_n,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_dq_out,
   output logic              mem_dq_oe,
   input  logic [DATA_W-1:0] mem_dq_in
);

   localparam int RD_N  = imax(ns_to_cycles(T_RC_NS, CLK_NS), ns_to_cycles(T_OE_NS, CLK_NS));
   localparam int HZ_N  = ns_to_cycles(T_HZ_NS, CLK_NS);
   localparam int DW_N  = ns_to_cycles(T_DW_NS, CLK_NS);
   localparam int WP_N  = ns_to_cycles(T_WP_NS, CLK_NS);
   localparam int AW_N  = ns_to_cycles(T_AW_NS, CLK_NS);
   localparam int WC_N  = ns_to_cycles(T_WC_NS, CLK_NS);
   localparam int DRV_N = imax(DW_N, imax(WP_N - HZ_N, AW_N - HZ_N));
   localparam int REC_N = imax(1, WC_N - HZ_N - DRV_N);
   localparam int MAX_N = imax(RD_N, imax(HZ_N, imax(DRV_N, REC_N)));
   localparam int CNT_W = $clog2(MAX_N + 1);

   generate
      if (CLK_NS < 1) begin : g_bad_clk
         $error("asram_ctl: CLK_NS must be at least 1");
      end
      if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
         $error("asram_ctl: ADDR_W and DATA_W must be positive");
      end
   endgenerate

   logic             tmr_load, tmr_done;
   logic [CNT_W-1:0] tmr_val;
   logic             accept, capture, idle;

   asram_wait_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .done     (tmr_done)
   );

   asram_phase_fsm #(
      .CNT_W (CNT_W),
      .RD_N  (RD_N),
      .HZ_N  (HZ_N),
      .DRV_N (DRV_N),
      .REC_N (REC_N)
   ) u_fsm (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_valid (req_valid),
      .req_write (req_write),
      .tmr_done  (tmr_done),
      .tmr_load  (tmr_load),
      .tmr_val   (tmr_val),
      .accept    (accept),
      .capture   (capture),
      .idle      (idle),
      .cs_n      (mem_cs_n),
      .oe_n      (mem_oe_n),
      .we_n      (mem_we_n),
      .dq_oe     (mem_dq_oe)
   );

   asram_data_path #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_data (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .capture    (capture),
      .req_addr   (req_addr),
      .req_wdata  (req_wdata),
      .mem_dq_in  (mem_dq_in),
      .mem_addr   (mem_addr),
      .mem_dq_out (mem_dq_out),
      .rsp_valid  (rsp_valid),
      .rsp_rdata  (rsp_rdata)
   );

   assign req_ready = idle;

   // R2: output enable low only with a read encoding and the pad released
   p_read_enc_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !mem_oe_n |-> (!mem_cs_n && mem_we_n && !mem_dq_oe));

   // R8: address frozen while the memory is selected
   p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!mem_cs_n && $past(!mem_cs_n)) |-> $stable(mem_addr));

   // R9: ready never overlaps an access, read strobe lasts one cycle
   p_ready_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> mem_cs_n);
   p_rsp_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid);

   // R6: bus released on the edge that ends the write pulse
   p_release_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_we_n) |-> !mem_dq_oe);

endmodule

// File: tb/asram_ctl_tb.sv
`timescale 1ns/1ps
module asram_ctl_tb;

   localparam int CLK_NS = 4;
   localparam int RD_MIN = (70 + CLK_NS - 1) / CLK_NS;
   localparam int HZ_MIN = (30 + CLK_NS - 1) / CLK_NS;
   localparam int DW_MIN = (30 + CLK_NS - 1) / CLK_NS;
   localparam int WC_MIN = (70 + CLK_NS - 1) / CLK_NS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic        req_write = 1'b0;
   logic [17:0] req_addr = '0;
   logic [3:0]  req_wdata = '0;
   logic        rsp_valid;
   logic [3:0]  rsp_rdata;
   logic        mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe;
   logic [17:0] mem_addr;
   logic [3:0]  mem_dq_out;
   logic [3:0]  mem_dq_in = '0;

   always #2 clk = ~clk;

   asram_ctl #(.CLK_NS(CLK_NS)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
      .mem_addr(mem_addr), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
      .mem_dq_in(mem_dq_in)
   );

   int n_chk = 0;
   int n_bad = 0;
   int n_reads = 0;
   int n_rsp = 0;

   logic [3:0] mem_m [int];
   logic [3:0] ref_m [int];
   logic [3:0] exp_q [$];
   logic [17:0] addr_q [$];

   function automatic logic [3:0] init_word(input logic [17:0] a);
      return a[3:0] ^ a[7:4] ^ a[17:14];
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
      end
   endtask

   // monitor state
   logic        p_cs = 1'b1, p_oe = 1'b1, p_we = 1'b1, p_dqoe = 1'b0, p_rsp = 1'b0;
   logic [17:0] p_addr = '0;
   logic [3:0]  p_dq = '0;
   int oe_low = 0, rd_len = 0, we_low = 0, pre_drv = 0, drv = 0;
   int since_cs_fall = 1000, since_oe_rise = 1000;
   bit seen_cs_fall = 0;
   bit bad_rd_enc = 0, bad_wr_enc = 0, bad_addr = 0, bad_cont = 0, bad_dstable = 0;
   logic [17:0] acc_addr = '0;

   always @(negedge clk) begin
      if (rst_n) begin
         since_cs_fall++;
         since_oe_rise++;
         // memory model write at the end of the pulse
         if (!p_we && mem_we_n && !p_cs) mem_m[int'(p_addr)] = p_dq;
         // read side
         if (!mem_oe_n) begin
            oe_low++;
            if (mem_cs_n || !mem_we_n || mem_dq_oe) bad_rd_enc = 1;
         end
         if (!p_oe && mem_oe_n) begin
            rd_len = oe_low;
            oe_low = 0;
            since_oe_rise = 1;
         end
         if (!mem_oe_n && !mem_cs_n) begin
            if (oe_low * CLK_NS >= 70)
               mem_dq_in = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : init_word(mem_addr);
            else
               mem_dq_in = ~(mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : init_word(mem_addr));
         end else
            mem_dq_in = 4'h0;
         // contention window
         if (mem_dq_oe && (!mem_oe_n || since_oe_rise < HZ_MIN)) bad_cont = 1;
         // write side
         if (!mem_we_n) begin
            we_low++;
            if (mem_cs_n || !mem_oe_n) bad_wr_enc = 1;
            if (mem_dq_oe) begin
               drv++;
               if (p_dqoe && mem_dq_out != p_dq) bad_dstable = 1;
            end else if (drv == 0) pre_drv++;
            else bad_cont = 1;
         end
         if (!p_we && mem_we_n) begin
            // R5: pulse width in ns against both minimums
            check(we_low * CLK_NS >= 45 && we_low * CLK_NS >= 60, "R5 we_n low width", we_low * CLK_NS, 60);
            // R6: settle gap, drive length, release, contention
            check(pre_drv >= HZ_MIN, "R6 gap before drive", pre_drv, HZ_MIN);
            check(drv >= DW_MIN && !bad_dstable, "R6 data held before end", drv, DW_MIN);
            check(!mem_dq_oe && !bad_cont, "R6 bus released / no contention", int'(mem_dq_oe), 0);
            // R3: encoding over the pulse
            check(!bad_wr_enc, "R3 write encoding", int'(bad_wr_enc), 0);
            we_low = 0; pre_drv = 0; drv = 0; bad_wr_enc = 0; bad_dstable = 0;
         end
         // chip select cycle and address hold
         if (p_cs && !mem_cs_n) begin
            if (seen_cs_fall) check(since_cs_fall >= WC_MIN, "R7 cs fall spacing", since_cs_fall, WC_MIN);
            seen_cs_fall = 1;
            since_cs_fall = 0;
            if (addr_q.size() > 0) acc_addr = addr_q.pop_front();
            if (mem_addr != acc_addr) bad_addr = 1;
         end
         if (!p_cs && !mem_cs_n && mem_addr != p_addr) bad_addr = 1;
         if (!p_cs && mem_cs_n) begin
            check(!bad_addr, "R8 address held", int'(p_addr), int'(acc_addr));
            bad_addr = 0;
         end
         // scoreboard
         if (rsp_valid) begin
            n_rsp++;
            check(!p_rsp, "R9 rsp_valid single pulse", int'(p_rsp), 0);
            check(rd_len >= RD_MIN, "R4 read strobe length", rd_len, RD_MIN);
            check(!bad_rd_enc, "R2 read encoding", int'(bad_rd_enc), 0);
            bad_rd_enc = 0;
            if (exp_q.size() == 0)
               check(0, "R9 unexpected response", int'(rsp_rdata), -1);
            else begin
               logic [3:0] e;
               e = exp_q.pop_front();
               check(rsp_rdata == e, "R10 read data", int'(rsp_rdata), int'(e));
            end
         end
         if (!mem_cs_n && req_ready) check(0, "R9 ready during access", 1, 0);
         p_cs = mem_cs_n; p_oe = mem_oe_n; p_we = mem_we_n; p_dqoe = mem_dq_oe;
         p_addr = mem_addr; p_dq = mem_dq_out; p_rsp = rsp_valid;
      end
   end

   // driver: waits for ready, pushes expected items for reads
   task automatic access(input bit wr, input logic [17:0] a, input logic [3:0] d);
      bit took;
      @(posedge clk); #1;
      req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
      took = 0;
      while (!took) begin
         @(negedge clk); took = req_ready;
         @(posedge clk);
      end
      #1 req_valid = 1'b0;
      addr_q.push_back(a);
      if (wr) ref_m[int'(a)] = d;
      else begin
         n_reads++;
         exp_q.push_back(ref_m.exists(int'(a)) ? ref_m[int'(a)] : init_word(a));
      end
   endtask

   task automatic run_tests();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1: state held in reset
      check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && !rsp_valid, "R1 strobes in reset",
            int'({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe}), 14);
      @(posedge clk); #1 rst_n = 1'b1;
      @(negedge clk);
      check(mem_cs_n && mem_oe_n && mem_we_n && !mem_dq_oe && req_ready && !rsp_valid,
            "R1 state after reset", int'({mem_cs_n, mem_oe_n, mem_we_n, mem_dq_oe, req_ready}), 29);
      access(1, 18'h00000, 4'h5);
      access(1, 18'h3FFFF, 4'hA);
      access(1, 18'h00123, 4'hF);
      access(1, 18'h00124, 4'h0);
      access(0, 18'h00000, 4'h0);
      access(0, 18'h3FFFF, 4'h0);
      access(0, 18'h00123, 4'h0);
      access(0, 18'h00124, 4'h0);
      access(0, 18'h00777, 4'h0);   // never written
      access(1, 18'h00123, 4'h6);   // overwrite then read back
      access(0, 18'h00123, 4'h0);
      repeat (5) @(posedge clk);
      access(1, 18'h00000, 4'h9);
      access(1, 18'h00001, 4'h3);
      access(0, 18'h00001, 4'h0);
      access(0, 18'h00000, 4'h0);
      access(0, 18'h2AAAA, 4'h0);   // never written
      repeat (40) @(posedge clk);
      check(exp_q.size() == 0 && n_rsp == n_reads, "R9 one response per read", n_rsp, n_reads);
   endtask

   initial begin
      fork
         run_tests();
         begin
            repeat (50000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", n_rsp, n_reads);
         end
      join_any
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule